// File: doc/BRIEF.md
# Network Controller Reset Sequencer

This block takes the four ways a bus-mastering network controller can be reset and turns each one into the correct set of scoped clear pulses. The four sources are power-on, a qualified hardware reset pin, a software reset raised by reading a reset port, and a stop reset raised by writing the stop control bit. The clear targets are configuration space, the bus-configuration register group, the full command/status register group, two smaller command/status subsets, and a set of bits cleared only at power-on. Every accepted reset also restarts the internal microsequencer. The two hardware-level kinds then start an EEPROM reload and wait for it to report completion.

Bus request handling differs by kind. Power-on, hardware and software resets are abrupt: they drop the outgoing bus request in the cycle of the clear and pulse an abort towards the master engine. A stop reset instead waits in a pending state until the master engine reports that it is idle, with no queued accesses and the bus released. Only then does it clear its subset. During that wait the bus request keeps following the engine.

The block's own synchronous reset `rst` stands for the power-on source. A power-on sequence runs as soon as `rst` is released.

Top module: `nic_reset_seq`

## Requirements
- R1: A hardware reset is recognised only at the MIN_PULSE-th consecutive rising edge at which `hw_pin_i` and `pwr_good_i` are both sampled high. Shorter pulses, or a pin held high while power-good is low, cause nothing. One held assertion yields exactly one hardware reset.
- R2: In the cycle after the first rising edge at which `rst` is sampled low, `clr_cfg_o`, `clr_buscfg_o`, `clr_csr_o`, `clr_por_o` and `seq_restart_o` pulse together. One cycle later `ee_start_o` pulses.
- R3: A hardware reset pulses `clr_cfg_o`, `clr_buscfg_o`, `clr_csr_o` and `seq_restart_o` in the cycle after its recognising edge, with `clr_por_o` low, and pulses `ee_start_o` in the following cycle.
- R4: A `rst_port_rd_i` pulse sampled at an edge gives, in the next cycle, `clr_csr_sw_o` and `seq_restart_o`. It gives no configuration, bus-configuration, full command/status or power-on clear, and no `ee_start_o`.
- R5: `bus_req_o` is `mst_req_i` delayed by one cycle. In a cycle that carries a power-on, hardware or software clear it is forced low, and `mst_abort_o` pulses.
- R6: A `stop_wr_i` pulse arms a stop reset only if `stop_bit_i` is 0 at that edge. With `stop_bit_i` at 1 the write leaves all outputs unchanged, busy included.
- R7: An armed stop reset raises `busy_o` in the next cycle. It fires (`clr_csr_stop_o` and `seq_restart_o`) in the cycle after the first later edge at which `mst_idle_i` is sampled high. `bus_req_o` keeps following `mst_req_i` throughout.
- R8: A stop reset clears only the stop subset and restarts the sequencer. It produces no other clear, no abort and no `ee_start_o`.
- R9: Requests sampled at the same edge are served in the order power-on, hardware, software, stop, and lower ones are dropped. A software or hardware reset while a stop is pending cancels the stop. While an EEPROM load is being started or awaited, software reads and stop writes are ignored, and a new hardware reset restarts the sequence.
- R10: `busy_o` is high from the cycle after a reset is accepted. For software and stop resets it falls one cycle after the clear pulse. For power-on and hardware resets it falls in the cycle after `ee_done_i` is sampled high, once the EEPROM start has been issued.
- R11: Each accepted reset produces its clear pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the power-on source |
| hw_pin_i | input | 1 | Hardware reset pin, active high |
| pwr_good_i | input | 1 | Power-good qualifier for the reset pin |
| rst_port_rd_i | input | 1 | Single-cycle strobe: reset port was read |
| stop_wr_i | input | 1 | Single-cycle strobe: a 1 was written to the stop bit |
| stop_bit_i | input | 1 | Present value of the stop bit |
| mst_req_i | input | 1 | Bus request from the master engine |
| mst_idle_i | input | 1 | Master engine has no queued accesses and no bus ownership |
| ee_done_i | input | 1 | EEPROM reader reports the load finished |
| clr_cfg_o | output | 1 | Clear pulse: configuration space |
| clr_buscfg_o | output | 1 | Clear pulse: bus-configuration register group |
| clr_csr_o | output | 1 | Clear pulse: full command/status group |
| clr_csr_sw_o | output | 1 | Clear pulse: software-reset command/status subset |
| clr_csr_stop_o | output | 1 | Clear pulse: stop-reset command/status subset |
| clr_por_o | output | 1 | Clear pulse: power-on-only bits |
| seq_restart_o | output | 1 | Restart pulse to the microsequencer |
| ee_start_o | output | 1 | Start pulse to the EEPROM reader |
| mst_abort_o | output | 1 | Abrupt abort pulse to the master engine |
| bus_req_o | output | 1 | Bus request towards the system bus |
| busy_o | output | 1 | Reset sequence in progress |

## Verification
The assertions assume that reset-port reads and stop writes are single-cycle strobes that never come in consecutive cycles. They also assume that `ee_done_i` is raised only after `ee_start_o`, and that `stop_bit_i` truly mirrors the register file. The stimulus keeps to these limits: every strobe lasts one cycle and is followed by idle cycles, and the completion signal is raised several cycles after the EEPROM start. Hardware pin pulses are held for the whole intended width while power-good stays constant. Priority cases are set up by stacking strobes on one edge, and by issuing higher-priority resets while a stop is pending or a load is awaited.

// File: rtl/nrs_pkg.sv
`timescale 1ns/1ps
package nrs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_STOP_WAIT,
    PH_EE_START,
    PH_EE_WAIT
  } phase_t;

  typedef enum logic [2:0] {
    K_NONE,
    K_POR,
    K_HW,
    K_SW,
    K_STOP_ARM,
    K_STOP_FIRE
  } kind_t;

endpackage

// File: rtl/nrs_pin_filter.sv
`timescale 1ns/1ps
module nrs_pin_filter #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pg_i,
  output logic evt_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_PULSE);

  logic [CW-1:0] run_q;
  logic          qual;

  assign qual  = pin_i && pg_i;
  assign evt_o = qual && (run_q == LAST);

  // run length of qualified pin samples, saturating once the event has fired
  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      run_q <= '0;
    end else if (run_q != FULL) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_ONE_EVT_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o); // R1

endmodule

// File: rtl/nrs_arbiter.sv
`timescale 1ns/1ps
module nrs_arbiter
  import nrs_pkg::*;
(
  input  phase_t phase_i,
  input  logic   por_pend_i,
  input  logic   hw_evt_i,
  input  logic   sw_req_i,
  input  logic   stop_wr_i,
  input  logic   stop_bit_i,
  input  logic   mst_idle_i,
  output kind_t  kind_o
);
  logic ee_phase;
  assign ee_phase = (phase_i == PH_EE_START) || (phase_i == PH_EE_WAIT);

  // fixed priority: power-on, hardware, software, stop
  always_comb begin
    kind_o = K_NONE;
    if (por_pend_i) begin
      kind_o = K_POR;
    end else if (hw_evt_i) begin
      kind_o = K_HW;
    end else if (sw_req_i && !ee_phase) begin
      kind_o = K_SW;
    end else if ((phase_i == PH_STOP_WAIT) && mst_idle_i) begin
      kind_o = K_STOP_FIRE;
    end else if (stop_wr_i && !stop_bit_i && (phase_i == PH_IDLE)) begin
      kind_o = K_STOP_ARM;
    end
  end

endmodule

// File: rtl/nic_reset_seq.sv
`timescale 1ns/1ps
module nic_reset_seq
  import nrs_pkg::*;
#(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_pin_i,
  input  logic pwr_good_i,
  input  logic rst_port_rd_i,
  input  logic stop_wr_i,
  input  logic stop_bit_i,
  input  logic mst_req_i,
  input  logic mst_idle_i,
  input  logic ee_done_i,
  output logic clr_cfg_o,
  output logic clr_buscfg_o,
  output logic clr_csr_o,
  output logic clr_csr_sw_o,
  output logic clr_csr_stop_o,
  output logic clr_por_o,
  output logic seq_restart_o,
  output logic ee_start_o,
  output logic mst_abort_o,
  output logic bus_req_o,
  output logic busy_o
);
  phase_t phase_q, phase_d;
  kind_t  kind;
  logic   por_pend_q;
  logic   hw_evt;
  logic   hw_like, abrupt;

  nrs_pin_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .pin_i (hw_pin_i),
    .pg_i  (pwr_good_i),
    .evt_o (hw_evt)
  );

  nrs_arbiter u_arb (
    .phase_i    (phase_q),
    .por_pend_i (por_pend_q),
    .hw_evt_i   (hw_evt),
    .sw_req_i   (rst_port_rd_i),
    .stop_wr_i  (stop_wr_i),
    .stop_bit_i (stop_bit_i),
    .mst_idle_i (mst_idle_i),
    .kind_o     (kind)
  );

  assign hw_like = (kind == K_POR) || (kind == K_HW);
  assign abrupt  = hw_like || (kind == K_SW);

  always_comb begin
    phase_d = phase_q;
    case (kind)
      K_POR, K_HW:        phase_d = PH_EE_START;
      K_SW, K_STOP_FIRE:  phase_d = PH_IDLE;
      K_STOP_ARM:         phase_d = PH_STOP_WAIT;
      default: begin
        case (phase_q)
          PH_EE_START: phase_d = PH_EE_WAIT;
          PH_EE_WAIT:  phase_d = ee_done_i ? PH_IDLE : PH_EE_WAIT;
          default:     phase_d = phase_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_pend_q     <= 1'b1;
      phase_q        <= PH_IDLE;
      clr_cfg_o      <= 1'b0;
      clr_buscfg_o   <= 1'b0;
      clr_csr_o      <= 1'b0;
      clr_csr_sw_o   <= 1'b0;
      clr_csr_stop_o <= 1'b0;
      clr_por_o      <= 1'b0;
      seq_restart_o  <= 1'b0;
      ee_start_o     <= 1'b0;
      mst_abort_o    <= 1'b0;
      bus_req_o      <= 1'b0;
      busy_o         <= 1'b0;
    end else begin
      por_pend_q     <= 1'b0;
      phase_q        <= phase_d;
      clr_cfg_o      <= hw_like;
      clr_buscfg_o   <= hw_like;
      clr_csr_o      <= hw_like;
      clr_csr_sw_o   <= (kind == K_SW);
      clr_csr_stop_o <= (kind == K_STOP_FIRE);
      clr_por_o      <= (kind == K_POR);
      seq_restart_o  <= hw_like || (kind == K_SW) || (kind == K_STOP_FIRE);
      ee_start_o     <= (phase_q == PH_EE_START) && !hw_like;
      mst_abort_o    <= abrupt;
      bus_req_o      <= mst_req_i && !abrupt;
      busy_o         <= (kind != K_NONE) || (phase_d != PH_IDLE);
    end
  end

  AST_HW_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (clr_cfg_o && !clr_por_o) |-> $past(hw_pin_i && pwr_good_i)); // R1
  AST_POR_SUPERSET: assert property (@(posedge clk) disable iff (rst)
    clr_por_o |-> (clr_cfg_o && clr_buscfg_o && clr_csr_o)); // R2
  AST_EE_FOLLOWS_HW: assert property (@(posedge clk) disable iff (rst)
    ee_start_o |-> $past(clr_cfg_o)); // R3
  AST_SW_SCOPE: assert property (@(posedge clk) disable iff (rst)
    clr_csr_sw_o |-> (!clr_cfg_o && !clr_buscfg_o && !clr_csr_o && !ee_start_o)); // R4
  AST_SW_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    clr_csr_sw_o |-> (!bus_req_o && mst_abort_o)); // R5
  AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    clr_csr_stop_o |-> $past(mst_idle_i)); // R7
  AST_STOP_SCOPE: assert property (@(posedge clk) disable iff (rst)
    clr_csr_stop_o |-> (!clr_cfg_o && !clr_csr_sw_o && !ee_start_o && !mst_abort_o)); // R8
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    (seq_restart_o || ee_start_o) |-> busy_o); // R10

endmodule

// File: tb/nic_reset_seq_bench.sv
`timescale 1ns/1ps
module nic_reset_seq_bench;
  localparam int MINP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic pin = 1'b0, pg = 1'b1, rd = 1'b0, swr = 1'b0, sbit = 1'b0;
  logic mreq = 1'b0, midle = 1'b1, eed = 1'b0;
  logic clr_cfg, clr_buscfg, clr_csr, clr_sw, clr_stop, clr_por;
  logic restart, ee_start, abort, bus_req, busy;

  nic_reset_seq #(.MIN_PULSE(MINP)) u_nic_reset_seq (
    .clk(clk), .rst(rst), .hw_pin_i(pin), .pwr_good_i(pg),
    .rst_port_rd_i(rd), .stop_wr_i(swr), .stop_bit_i(sbit),
    .mst_req_i(mreq), .mst_idle_i(midle), .ee_done_i(eed),
    .clr_cfg_o(clr_cfg), .clr_buscfg_o(clr_buscfg), .clr_csr_o(clr_csr),
    .clr_csr_sw_o(clr_sw), .clr_csr_stop_o(clr_stop), .clr_por_o(clr_por),
    .seq_restart_o(restart), .ee_start_o(ee_start), .mst_abort_o(abort),
    .bus_req_o(bus_req), .busy_o(busy)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: phase 0 idle, 1 stop pending, 2 load start, 3 load wait
  int  run_len = 0, phase = 0;
  bit  por_due = 1'b0;
  bit  e_cfg, e_csr, e_sw, e_stop, e_por, e_rst, e_ee, e_abort, e_req, e_busy;
  string tag = "R2";
  int  n_chk = 0, n_fail = 0;
  bit  p_cfg = 1'b0, p_sw = 1'b0, p_stop = 1'b0;

  always @(posedge clk) begin
    string k;
    bit hw_now;
    int nxt;
    if (rst) begin
      por_due = 1'b1; phase = 0; run_len = 0;
      {e_cfg, e_csr, e_sw, e_stop, e_por, e_rst, e_ee, e_abort, e_req, e_busy} = '0;
    end else begin
      hw_now = pin && pg && (run_len == MINP - 1);
      if (pin && pg) begin
        if (run_len < MINP) run_len++;
      end else run_len = 0;
      k = "none";
      if (por_due) k = "por";
      else if (hw_now) k = "hw";
      else if (rd && phase < 2) k = "sw";
      else if (phase == 1 && midle) k = "fire";
      else if (swr && !sbit && phase == 0) k = "arm";
      por_due = 1'b0;
      if (k == "por" || k == "hw") nxt = 2;
      else if (k == "sw" || k == "fire") nxt = 0;
      else if (k == "arm") nxt = 1;
      else if (phase == 2) nxt = 3;
      else if (phase == 3 && eed) nxt = 0;
      else nxt = phase;
      e_cfg   = (k == "por" || k == "hw");
      e_csr   = e_cfg;
      e_por   = (k == "por");
      e_sw    = (k == "sw");
      e_stop  = (k == "fire");
      e_rst   = e_cfg || e_sw || e_stop;
      e_ee    = (phase == 2) && !e_cfg;
      e_abort = e_cfg || e_sw;
      e_req   = mreq && !e_abort;
      e_busy  = (k != "none") || (nxt != 0);
      phase = nxt;
    end
  end

  task automatic chk(input string name, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("clr_cfg_o R3", clr_cfg, e_cfg);
    chk("clr_buscfg_o R3", clr_buscfg, e_cfg);
    chk("clr_csr_o R3", clr_csr, e_csr);
    chk("clr_por_o R2", clr_por, e_por);
    chk("clr_csr_sw_o R4", clr_sw, e_sw);
    chk("clr_csr_stop_o R7", clr_stop, e_stop);
    chk("seq_restart_o R8", restart, e_rst);
    chk("ee_start_o R3", ee_start, e_ee);
    chk("mst_abort_o R5", abort, e_abort);
    chk("bus_req_o R5", bus_req, e_req);
    chk("busy_o R10", busy, e_busy);
    n_chk++;
    if ((clr_cfg && p_cfg) || (clr_sw && p_sw) || (clr_stop && p_stop)) begin
      n_fail++;
      $display("FAIL R11 clear held two cycles actual=1 expected=0 at %0t", $time);
    end
    p_cfg = clr_cfg; p_sw = clr_sw; p_stop = clr_stop;
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tag = "R2"; rst = 1'b1; tick(3); rst = 1'b0; tick(6);
    eed = 1'b1; tick(1); eed = 1'b0; tick(3);
    tag = "R5"; mreq = 1'b1; tick(3); mreq = 1'b0; tick(2);
    mreq = 1'b1; tick(1); mreq = 1'b0; tick(2);
    tag = "R1"; pin = 1'b1; tick(MINP - 1); pin = 1'b0; tick(3);
    pg = 1'b0; pin = 1'b1; tick(6); pin = 1'b0; pg = 1'b1; tick(2);
    tag = "R3"; pin = 1'b1; tick(MINP + 2); pin = 1'b0; tick(4);
    eed = 1'b1; tick(1); eed = 1'b0; tick(3);
    tag = "R4"; mreq = 1'b1; tick(2); rd = 1'b1; tick(1); rd = 1'b0; tick(4);
    mreq = 1'b0; tick(2);
    tag = "R6"; sbit = 1'b1; swr = 1'b1; tick(1); swr = 1'b0; tick(3); sbit = 1'b0;
    tag = "R7"; midle = 1'b0; mreq = 1'b1; swr = 1'b1; tick(1); swr = 1'b0; tick(5);
    midle = 1'b1; tick(3); mreq = 1'b0; tick(2);
    tag = "R8"; swr = 1'b1; tick(1); swr = 1'b0; tick(4);
    tag = "R9"; midle = 1'b0; swr = 1'b1; tick(1); swr = 1'b0; tick(3);
    rd = 1'b1; tick(1); rd = 1'b0; midle = 1'b1; tick(4);
    rd = 1'b1; swr = 1'b1; tick(1); rd = 1'b0; swr = 1'b0; tick(4);
    midle = 1'b0; swr = 1'b1; tick(1); swr = 1'b0; tick(2);
    pin = 1'b1; tick(MINP); pin = 1'b0; midle = 1'b1; tick(3);
    rd = 1'b1; tick(1); rd = 1'b0; tick(2);
    swr = 1'b1; tick(1); swr = 1'b0; tick(2);
    pin = 1'b1; tick(MINP); pin = 1'b0; tick(3);
    eed = 1'b1; tick(1); eed = 1'b0; tick(3);
    tag = "R10"; mreq = 1'b1; rst = 1'b1; tick(2); rst = 1'b0; tick(3);
    eed = 1'b1; tick(1); eed = 1'b0; mreq = 1'b0; tick(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule